// File: doc/BRIEF.md
# PS/2 Keyboard Receiver with Retransmit Recovery

This block takes the clock and data wires of a PS/2 keyboard, brings both into the system clock domain and rebuilds each 11-bit frame. It tracks its place in the frame by counting falling edges of the keyboard clock. Every frame that arrives intact places its byte into a small circular FIFO, which the host drains through a simple read strobe.

Some frames fail. The cause can be a bad start bit, a wrong parity bit, a missing stop bit, or a byte that stalls and never finishes. In any of these cases the block pulses an error flag. It then pulls the keyboard clock wire low for a fixed hold time, which breaks off the keyboard mid-byte and makes it send the byte again. The block never drives a line high: its only line output asks for the clock wire to be pulled low, and the external pull-up supplies the high level. A parameter sets how many system clocks make up one microsecond, and both the timeout and the hold time are derived from it.

Top module: `ps2_rx_retry`

## Requirements
- R1: After reset the FIFO is empty and not full, the overflow flag is 0, the error pulse is 0, the clock-hold output is 0 and the read data is 0x00.
- R2: Each falling edge of the synchronized keyboard clock samples one bit. A frame is a start bit of 0, then eight data bits with the least significant first, then a parity bit chosen so that the nine data and parity bits hold an odd number of ones, then a stop bit of 1. A frame that passes every check pushes its byte into the FIFO.
- R3: If the nine data and parity bits hold an even number of ones, the block raises the error output for exactly one cycle and does not store the byte.
- R4: A start bit of 1 or a stop bit of 0 is also a frame error (one-cycle error pulse, nothing stored).
- R5: A byte that has not completed CLKS_PER_US*TIMEOUT_US system cycles after its first falling edge is abandoned with a one-cycle error pulse.
- R6: Each error raises the clock-hold output in the same cycle as the error pulse and keeps it high for CLKS_PER_US*INHIBIT_US cycles. Falling edges during this time are ignored. Afterwards the next frame is decoded from a fresh start bit.
- R7: The FIFO holds up to DEPTH bytes in arrival order. A read strobe while the FIFO is not empty presents the oldest byte on the read data output in the following cycle.
- R8: A valid byte that arrives while the FIFO is full is dropped and sets the overflow flag, which stays set until reset.
- R9: A read strobe while the FIFO is empty leaves the read data output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Keyboard clock wire as read back (asynchronous) |
| ps2_dat_i | input | 1 | Keyboard data wire (asynchronous) |
| rd_en_i | input | 1 | Read strobe, pops one byte |
| rd_data_o | output | 8 | Last byte popped from the FIFO |
| empty_o | output | 1 | FIFO holds no byte |
| full_o | output | 1 | FIFO holds DEPTH bytes |
| overflow_o | output | 1 | Sticky: a valid byte was dropped |
| frame_err_o | output | 1 | One-cycle pulse on any frame error or timeout |
| clk_low_o | output | 1 | 1 asks the open-drain clock driver to pull the wire low |

## Verification
Some properties can be checked on every cycle. Each error pulse comes with the clock hold and lasts a single cycle, and the frame position is back at the start whenever a hold ends. A full FIFO cannot grow without a read. A read of the empty FIFO leaves the data as it was, the overflow flag stays set once set, and an open byte never runs past the timeout window. Other behaviour shows only through the bench's frame scenarios, which are compared cycle by cycle against a behavioural model: bit order, the odd-parity rule, bad start and stop bits, a stalled byte that ends in a timeout, decoding that resumes after a hold, and arrival order with drops at the full FIFO.

// File: rtl/ps2_rx_retry.sv
`timescale 1ns/1ps
module ps2_rx_retry #(
  parameter int CLKS_PER_US = 4,
  parameter int TIMEOUT_US  = 2000,
  parameter int INHIBIT_US  = 100,
  parameter int DEPTH       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  output logic       empty_o,
  output logic       full_o,
  output logic       overflow_o,
  output logic       frame_err_o,
  output logic       clk_low_o
);
  localparam int TO_CYC  = CLKS_PER_US * TIMEOUT_US;
  localparam int INH_CYC = CLKS_PER_US * INHIBIT_US;
  localparam int TW = $clog2(TO_CYC + 1);
  localparam int IW = $clog2(INH_CYC + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [2:0]    csync;
  logic [1:0]    dsync;
  logic [3:0]    pos;
  logic [7:0]    shreg;
  logic          par;
  logic [TW-1:0] tcnt;
  logic [IW-1:0] icnt;
  logic [AW:0]   wptr, rptr;
  logic [7:0]    mem [DEPTH];

  wire fall    = csync[2] & ~csync[1];
  wire dbit    = dsync[1];
  wire busy    = pos != 4'd0;
  wire timeout = busy && !clk_low_o && tcnt == TW'(TO_CYC - 1);
  wire edge_ok = fall && !clk_low_o && !timeout;
  wire par_ok  = ^{shreg, par};
  wire bad_end = pos == 4'd10 && (!dbit || !par_ok);
  wire bad_beg = pos == 4'd0 && dbit;
  wire err_now = timeout || (edge_ok && (bad_end || bad_beg));
  wire good    = edge_ok && pos == 4'd10 && dbit && par_ok;
  wire [AW:0] level = wptr - rptr;

  assign empty_o = level == '0;
  assign full_o  = level == (AW+1)'(DEPTH);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      csync <= 3'b111;
      dsync <= 2'b11;
    end else begin
      csync <= {csync[1:0], ps2_clk_i};
      dsync <= {dsync[0], ps2_dat_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos   <= '0;
      shreg <= '0;
      par   <= 1'b0;
      tcnt  <= '0;
    end else if (err_now) begin
      pos <= '0;
    end else if (edge_ok) begin
      pos <= (pos == 4'd10) ? 4'd0 : pos + 4'd1;
      if (pos >= 4'd1 && pos <= 4'd8) shreg <= {dbit, shreg[7:1]};
      if (pos == 4'd9) par <= dbit;
      tcnt <= busy ? tcnt + 1'b1 : '0;
    end else if (busy) begin
      tcnt <= tcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_low_o   <= 1'b0;
      icnt        <= '0;
      frame_err_o <= 1'b0;
    end else begin
      frame_err_o <= err_now;
      if (err_now) begin
        clk_low_o <= 1'b1;
        icnt      <= '0;
      end else if (clk_low_o) begin
        if (icnt == IW'(INH_CYC - 1)) clk_low_o <= 1'b0;
        icnt <= icnt + 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (good && !full_o) mem[wptr[AW-1:0]] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      rd_data_o  <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (good && !full_o) wptr <= wptr + 1'b1;
      if (good && full_o) overflow_o <= 1'b1;
      if (rd_en_i && !empty_o) begin
        rd_data_o <= mem[rptr[AW-1:0]];
        rptr      <= rptr + 1'b1;
      end
    end

  AST_ERR_HOLDS_CLK: assert property (@(posedge clk) disable iff (!rst_n) frame_err_o |-> clk_low_o); // R6
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) frame_err_o |=> !frame_err_o); // R3
  AST_FRESH_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(clk_low_o) |-> pos == 4'd0); // R6
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> tcnt < TW'(TO_CYC)); // R5
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n) full_o && !rd_en_i |=> full_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow_o |=> overflow_o); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) empty_o && rd_en_i |=> $stable(rd_data_o)); // R9
  AST_LEVEL_SANE: assert property (@(posedge clk) disable iff (!rst_n) !(empty_o && full_o)); // R7
endmodule

// File: tb/test_ps2_rx_retry.sv
`timescale 1ns/1ps
module test_ps2_rx_retry;
  localparam int CPU = 4, TOU = 2000, INU = 100, DEPTH = 4;
  localparam int TO_CYC = CPU * TOU, INH_CYC = CPU * INU, HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0, kb_clk = 1'b1, kb_dat = 1'b1, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic empty, full, ovf, ferr, clk_low;
  wire line_clk = kb_clk & ~clk_low;

  always #2 clk = ~clk;

  ps2_rx_retry #(.CLKS_PER_US(CPU), .TIMEOUT_US(TOU), .INHIBIT_US(INU), .DEPTH(DEPTH)) i_ps2_rx_retry (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(line_clk), .ps2_dat_i(kb_dat), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .empty_o(empty), .full_o(full), .overflow_o(ovf),
    .frame_err_o(ferr), .clk_low_o(clk_low));

  int vectors = 0, fails = 0, errs_seen = 0;
  bit done = 0;

  // behavioural reference
  logic [2:0] m_c = 3'b111;
  logic [1:0] m_d = 2'b11;
  int m_pos = 0, m_t = 0, m_i = 0;
  bit m_inh = 0, m_err = 0, m_ovf = 0, m_par = 0;
  logic [7:0] m_sh = 0, m_rd = 0;
  logic [7:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c = 3'b111; m_d = 2'b11; m_pos = 0; m_t = 0; m_i = 0;
      m_inh = 0; m_err = 0; m_ovf = 0; m_par = 0; m_sh = 0; m_rd = 0; q.delete();
    end else begin
      bit fl, db, to, gd, was_full, was_busy;
      fl = m_c[2] && !m_c[1];
      db = m_d[1];
      was_busy = m_pos != 0;
      to = was_busy && !m_inh && m_t == TO_CYC - 1;
      gd = 0;
      m_err = 0;
      if (m_inh) begin
        if (m_i == INH_CYC - 1) m_inh = 0;
        m_i++;
      end else if (to) begin
        m_err = 1;
      end else if (fl) begin
        if (m_pos == 0) begin
          if (db) m_err = 1; else begin m_pos = 1; m_t = 0; end
        end else begin
          m_t++;
          if (m_pos <= 8) begin m_sh = {db, m_sh[7:1]}; m_pos++; end
          else if (m_pos == 9) begin m_par = db; m_pos++; end
          else begin
            if (db && ($countones({m_sh, m_par}) % 2 == 1)) begin gd = 1; m_pos = 0; end
            else m_err = 1;
          end
        end
      end else if (was_busy) m_t++;
      if (m_err) begin m_inh = 1; m_i = 0; m_pos = 0; end
      was_full = q.size() == DEPTH;
      if (rd_en && q.size() > 0) m_rd = q.pop_front();
      if (gd) begin if (was_full) m_ovf = 1; else q.push_back(m_sh); end
      m_c = {m_c[1:0], line_clk};
      m_d = {m_d[0], kb_dat};
    end
  end

  task automatic cmp(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (ferr) errs_seen++;
    cmp(rd_data, m_rd, "R7", "rd_data");
    cmp(8'(empty), 8'(q.size() == 0), "R7", "empty");
    cmp(8'(full), 8'(q.size() == DEPTH), "R8", "full");
    cmp(8'(ovf), 8'(m_ovf), "R8", "overflow");
    cmp(8'(ferr), 8'(m_err), "R3", "frame_err");
    cmp(8'(clk_low), 8'(m_inh), "R6", "clk_low");
  end

  function automatic logic [10:0] mkframe(input logic [7:0] b, input bit flip_par, input bit stop, input bit start);
    return {stop, (~^b) ^ flip_par, b, start};
  endfunction

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send(input logic [10:0] f, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk); kb_dat = f[k];
      wait_cyc(HALF); kb_clk = 1'b0;
      wait_cyc(HALF); kb_clk = 1'b1;
    end
    @(negedge clk); kb_dat = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic pop_check(input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    cmp(rd_data, exp, tag, "popped byte");
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int e0;
    wait_cyc(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp(rd_data, 8'h00, "R1", "rd_data");
    cmp(8'({empty, full, ovf, ferr, clk_low}), 8'b10000, "R1", "flags");
    // R2 valid frames, several patterns
    send(mkframe(8'h1C, 0, 1, 0), 11);
    pop_check(8'h1C, "R2");
    send(mkframe(8'hA5, 0, 1, 0), 11);
    send(mkframe(8'h00, 0, 1, 0), 11);
    send(mkframe(8'hFF, 0, 1, 0), 11);
    pop_check(8'hA5, "R7");
    pop_check(8'h00, "R7");
    pop_check(8'hFF, "R7");
    // R3 parity error
    e0 = errs_seen;
    send(mkframe(8'h3C, 1, 1, 0), 11);
    cmp(8'(clk_low), 8'd1, "R6", "hold after parity error");
    wait_cyc(INH_CYC);
    cmp(8'(errs_seen - e0), 8'd1, "R3", "parity error pulses");
    cmp(8'(empty), 8'd1, "R3", "bad byte not stored");
    // R4 stop bit 0, then start bit 1
    e0 = errs_seen;
    send(mkframe(8'h5A, 0, 0, 0), 11);
    wait_cyc(INH_CYC);
    cmp(8'(errs_seen - e0), 8'd1, "R4", "stop error pulses");
    e0 = errs_seen;
    send(mkframe(8'h5A, 0, 1, 1), 1);
    wait_cyc(INH_CYC);
    cmp(8'(errs_seen - e0), 8'd1, "R4", "start error pulses");
    cmp(8'(empty), 8'd1, "R4", "nothing stored");
    // R5 stalled byte times out
    e0 = errs_seen;
    send(mkframe(8'h77, 0, 1, 0), 6);
    wait_cyc(TO_CYC - 6 * 2 * HALF + 100);
    cmp(8'(errs_seen - e0), 8'd1, "R5", "timeout pulses");
    cmp(8'(clk_low), 8'd1, "R6", "hold during timeout recovery");
    wait_cyc(INH_CYC);
    cmp(8'(clk_low), 8'd0, "R6", "hold released");
    // R6 fresh decode after hold
    send(mkframe(8'h77, 0, 1, 0), 11);
    pop_check(8'h77, "R6");
    // R8 overflow
    send(mkframe(8'h11, 0, 1, 0), 11);
    send(mkframe(8'h22, 0, 1, 0), 11);
    send(mkframe(8'h33, 0, 1, 0), 11);
    send(mkframe(8'h44, 0, 1, 0), 11);
    cmp(8'(ovf), 8'd0, "R8", "no overflow yet");
    send(mkframe(8'h55, 0, 1, 0), 11);
    cmp(8'(ovf), 8'd1, "R8", "overflow set");
    pop_check(8'h11, "R8");
    pop_check(8'h22, "R8");
    pop_check(8'h33, "R8");
    pop_check(8'h44, "R8");
    // R9 empty read
    pop_check(8'h44, "R9");
    cmp(8'(ovf), 8'd1, "R8", "overflow sticky");
    wait_cyc(10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule